// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block runs the host side of a serial link to an 8-bit sampling converter. It uses chip select, serial clock, a host-to-converter data line and a converter-to-host data line. The host logic raises a start request. The controller then lowers chip select and produces the serial clock by dividing the system clock. It lets the sample window and the null bits pass without using them. It then collects the eight result bits, most significant bit first. Chip select is released after the last bit, and the byte is presented with a one-cycle valid strobe.

A parameter picks one of two framings. In plain differential framing no configuration is sent, and a frame lasts 12 serial clocks. In two-channel framing a frame lasts 16 serial clocks. The controller first shifts out a start bit, then a single-ended/differential select bit, then an odd/sign select bit. Together these choose channel 0 or channel 1 against ground, or the difference between the two channels in either polarity.

The controller is a single state machine. Its states are IDLE, SETUP, HIGH, LOW, DONE and GAP.
- IDLE goes to SETUP on a start request.
- SETUP goes to HIGH after one half period.
- HIGH goes to LOW after a half period, or to DONE after the last rising edge.
- LOW goes back to HIGH after a half period.
- DONE goes to GAP after one cycle.
- GAP goes to IDLE after two half periods.

Top module: `sadc_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip select is high, the serial clock is low, and busy and valid are low.
- R2: A start request in IDLE lowers chip select and raises busy at the next clock edge. Chip select then stays low for at least DIV system cycles before the first rising serial-clock edge.
- R3: Each serial-clock phase lasts DIV system cycles, so one transfer holds chip select low for exactly 2·FRAME·DIV system cycles.
- R4: A frame has exactly 12 rising serial-clock edges in plain framing (MUX_MODE=0) and 16 in two-channel framing (MUX_MODE=1).
- R5: In two-channel framing the host data line carries 1, then sel_i[1] (1 = single-ended, 0 = differential), then sel_i[0] (odd/sign), on the first three rising edges. sel_i is latched at start. In plain framing, and whenever chip select is high, the line stays 0.
- R6: The converter data line is sampled on rising serial-clock edges. Only the last eight edges of a frame are kept, as B7 down to B0. Values on all earlier edges have no effect on the result.
- R7: Chip select rises with the serial clock low in the cycle after the last high phase. In that same cycle valid_o pulses for exactly one cycle, and result_o holds the byte until the next valid_o.
- R8: A start request while busy is high is ignored: it starts no frame and does not change the select bits of the running frame.
- R9: Between consecutive frames chip select stays high for at least 2·DIV system cycles, one serial-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, acted on in IDLE only |
| sel_i | input | 2 | Channel select: [1] single-ended/differential, [0] odd/sign |
| busy_o | output | 1 | High from start until the controller is back in IDLE |
| valid_o | output | 1 | One-cycle strobe, result_o is new |
| result_o | output | 8 | Converted byte, B7 in bit 7 |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Host-to-converter data |
| miso_i | input | 1 | Converter-to-host data |

## Verification
The bench builds two instances. One uses two-channel framing with DIV=2, so every phase lasts two cycles and all four select codes, the 16-edge frame and the 64-cycle low time can be observed. The other uses plain framing with DIV=1, which covers the 12-edge frame at the fastest divider, where each phase is a single system cycle. The converter model drives ones on every non-data edge, so a capture window placed wrongly shows up in the result. Holding start high on the DIV=2 instance brings the chip-select-high gap within reach.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_DONE,
        ST_GAP
    } sadc_state_t;

    localparam int CFG_BITS = 3;

    function automatic int frame_len(input bit mux);
        return mux ? 16 : 12;
    endfunction

endpackage

// File: rtl/sadc_clkdiv.sv
module sadc_clkdiv #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sadc_shreg.sv
module sadc_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= {q[W-2:0], din};
        end
    end
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl #(
    parameter bit MUX_MODE = 1'b1,
    parameter int DIV      = 2,
    parameter int RES_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       sel_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [RES_W-1:0] result_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             mosi_o,
    input  logic             miso_i
);
    import sadc_pkg::*;

    localparam int FRAME = frame_len(MUX_MODE);
    localparam int LEAD  = FRAME - RES_W;
    localparam int IDX_W = $clog2(FRAME);

    sadc_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             half_q, half_d;
    logic [1:0]       sel_q;
    logic             tick;
    logic             div_clr;
    logic             cap_en;
    logic             last_edge;
    logic [RES_W-1:0] shift_q;

    assign div_clr   = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign last_edge = (state_q == ST_HIGH) && tick && (idx_q == IDX_W'(FRAME - 1));
    assign cap_en    = tick && ((state_q == ST_SETUP) || (state_q == ST_LOW))
                       && (idx_q >= IDX_W'(LEAD));

    sadc_clkdiv #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (div_clr),
        .tick (tick)
    );

    sadc_shreg #(.W(RES_W)) u_shift (
        .clk (clk),
        .rst (rst),
        .en  (cap_en),
        .din (miso_i),
        .q   (shift_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            half_q  <= 1'b0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            half_q  <= half_d;
            if (state_q == ST_IDLE && start_i) begin
                sel_q <= sel_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        half_d  = half_q;
        unique case (state_q)
            ST_IDLE: begin
                idx_d  = '0;
                half_d = 1'b0;
                if (start_i) begin
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (idx_q == IDX_W'(FRAME - 1)) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_LOW;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (tick) begin
                    state_d = ST_HIGH;
                end
            end
            ST_DONE: begin
                state_d = ST_GAP;
                half_d  = 1'b0;
            end
            ST_GAP: begin
                if (tick) begin
                    if (half_q) begin
                        state_d = ST_IDLE;
                    end else begin
                        half_d = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // configuration bit for the current edge
    logic cfg_bit;
    generate
        if (MUX_MODE) begin : g_mux
            always_comb begin
                unique case (idx_q)
                    IDX_W'(0): cfg_bit = 1'b1;
                    IDX_W'(1): cfg_bit = sel_q[1];
                    IDX_W'(2): cfg_bit = sel_q[0];
                    default:   cfg_bit = 1'b0;
                endcase
            end
        end else begin : g_plain
            assign cfg_bit = 1'b0;
        end
    endgenerate

    // outputs
    always_comb begin
        busy_o = (state_q != ST_IDLE);
        cs_n_o = 1'b1;
        sclk_o = 1'b0;
        mosi_o = 1'b0;
        unique case (state_q)
            ST_SETUP, ST_LOW: begin
                cs_n_o = 1'b0;
                mosi_o = cfg_bit;
            end
            ST_HIGH: begin
                cs_n_o = 1'b0;
                sclk_o = 1'b1;
                mosi_o = cfg_bit;
            end
            default: begin
                cs_n_o = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            result_o <= '0;
        end else begin
            valid_o <= last_edge;
            if (last_edge) begin
                result_o <= shift_q;
            end
        end
    end
endmodule

// File: rtl/sadc_ctrl_chk.sv
module sadc_ctrl_chk #(
    parameter bit MUX_MODE = 1'b1,
    parameter int DIV      = 2
) (
    input logic clk,
    input logic rst,
    input logic busy_o,
    input logic valid_o,
    input logic cs_n_o,
    input logic sclk_o,
    input logic mosi_o
);
    localparam int FRAME = sadc_pkg::frame_len(MUX_MODE);

    int   rise_cnt;
    int   low_cnt;
    int   high_cnt;
    logic sclk_q;
    logic seen_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_cnt   <= 0;
            low_cnt    <= 0;
            high_cnt   <= 0;
            sclk_q     <= 1'b0;
            seen_frame <= 1'b0;
        end else begin
            sclk_q <= sclk_o;
            if (cs_n_o) begin
                rise_cnt <= 0;
                low_cnt  <= 0;
                if (high_cnt < 1000000) high_cnt <= high_cnt + 1;
            end else begin
                high_cnt   <= 0;
                seen_frame <= 1'b1;
                if (low_cnt < 1000000) low_cnt <= low_cnt + 1;
                if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 1;
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (cs_n_o && !sclk_o && !busy_o && !valid_o));

    // R2
    setup_time_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && $rose(sclk_o)) |-> (low_cnt >= DIV));

    // R4
    frame_edges_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> (rise_cnt == FRAME));

    // R5
    mosi_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n_o || !MUX_MODE) |-> !mosi_o);

    // R7
    sclk_parked_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

    // R7
    valid_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $rose(cs_n_o));

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R8
    start_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> $rose(busy_o));

    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n_o) && seen_frame) |-> (high_cnt >= 2 * DIV));
endmodule

bind sadc_ctrl sadc_ctrl_chk #(.MUX_MODE(MUX_MODE), .DIV(DIV)) u_sadc_ctrl_chk (
    .clk     (clk),
    .rst     (rst),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o)
);

// File: tb/test_sadc_ctrl.sv
module sadc_adc_model #(
    parameter int FRAME = 16
) (
    input  logic       clk,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic [7:0] data,
    output logic       miso,
    output logic [2:0] cfg,
    output int         rises,
    output int         low_cyc,
    output int         gap_cyc,
    output logic       mosi_hi
);
    localparam int LEAD = FRAME - 8;
    int   low_run = 0;
    int   gap_run = 0;
    logic prev    = 1'b1;

    initial begin
        miso    = 1'b1;
        cfg     = '0;
        rises   = 0;
        low_cyc = 0;
        gap_cyc = 0;
        mosi_hi = 1'b0;
    end

    always @(negedge cs_n) begin
        rises   = 0;
        cfg     = '0;
        mosi_hi = 1'b0;
        miso    = 1'b1;
    end

    always @(posedge cs_n) miso = 1'b1;

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (rises < 3) cfg[2 - rises] = mosi;
            if (mosi) mosi_hi = 1'b1;
            rises = rises + 1;
        end
    end

    // the next bit is launched on the falling edge; non-data bits read as 1
    always @(negedge sclk) begin
        if (!cs_n) begin
            if (rises >= LEAD && rises < FRAME) miso = data[7 - (rises - LEAD)];
            else miso = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!cs_n) begin
            if (prev) begin
                gap_cyc = gap_run;
                low_run = 0;
            end
            low_run = low_run + 1;
        end else begin
            if (!prev) begin
                low_cyc = low_run;
                gap_run = 0;
            end
            gap_run = gap_run + 1;
        end
        prev = cs_n;
    end
endmodule

module test_sadc_ctrl;
    localparam int DIV_A = 2;
    localparam int DIV_B = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic       start_a = 1'b0, start_b = 1'b0;
    logic [1:0] sel_a = '0, sel_b = '0;
    logic       busy_a, valid_a, cs_a, sclk_a, mosi_a, miso_a;
    logic       busy_b, valid_b, cs_b, sclk_b, mosi_b, miso_b;
    logic [7:0] res_a, res_b;
    logic [7:0] data_a = '0, data_b = '0;
    logic [2:0] cfg_a, cfg_b;
    int         rises_a, rises_b, low_a, low_b, gap_a, gap_b;
    logic       mhi_a, mhi_b;

    logic [7:0] exp_a[$];
    logic [7:0] exp_b[$];
    int         valid_cnt_a = 0;

    sadc_ctrl #(.MUX_MODE(1'b1), .DIV(DIV_A), .RES_W(8)) i_sadc_ctrl (
        .clk(clk), .rst(rst), .start_i(start_a), .sel_i(sel_a),
        .busy_o(busy_a), .valid_o(valid_a), .result_o(res_a),
        .cs_n_o(cs_a), .sclk_o(sclk_a), .mosi_o(mosi_a), .miso_i(miso_a)
    );

    sadc_ctrl #(.MUX_MODE(1'b0), .DIV(DIV_B), .RES_W(8)) i_sadc_ctrl_plain (
        .clk(clk), .rst(rst), .start_i(start_b), .sel_i(sel_b),
        .busy_o(busy_b), .valid_o(valid_b), .result_o(res_b),
        .cs_n_o(cs_b), .sclk_o(sclk_b), .mosi_o(mosi_b), .miso_i(miso_b)
    );

    sadc_adc_model #(.FRAME(16)) u_adc_a (
        .clk(clk), .cs_n(cs_a), .sclk(sclk_a), .mosi(mosi_a), .data(data_a),
        .miso(miso_a), .cfg(cfg_a), .rises(rises_a), .low_cyc(low_a),
        .gap_cyc(gap_a), .mosi_hi(mhi_a)
    );

    sadc_adc_model #(.FRAME(12)) u_adc_b (
        .clk(clk), .cs_n(cs_b), .sclk(sclk_b), .mosi(mosi_b), .data(data_b),
        .miso(miso_b), .cfg(cfg_b), .rises(rises_b), .low_cyc(low_b),
        .gap_cyc(gap_b), .mosi_hi(mhi_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitors
    always @(negedge clk) begin
        if (!rst && valid_a) begin
            valid_cnt_a++;
            check(cs_a && !sclk_a, "R7 release A", {cs_a, sclk_a}, 2);
            if (exp_a.size() == 0) check(1'b0, "R8 unexpected result A", res_a, -1);
            else begin
                logic [7:0] e;
                e = exp_a.pop_front();
                check(res_a == e, "R6 data A", res_a, e);
            end
        end
        if (!rst && valid_b) begin
            check(cs_b && !sclk_b, "R7 release B", {cs_b, sclk_b}, 2);
            if (exp_b.size() == 0) check(1'b0, "R8 unexpected result B", res_b, -1);
            else begin
                logic [7:0] e;
                e = exp_b.pop_front();
                check(res_b == e, "R6 data B", res_b, e);
            end
        end
    end

    task automatic xfer_a(input logic [1:0] sel, input logic [7:0] byte_v);
        exp_a.push_back(byte_v);
        @(negedge clk);
        data_a  = byte_v;
        sel_a   = sel;
        start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        sel_a   = ~sel;
        check(busy_a && !cs_a && !sclk_a, "R2 start A", {busy_a, cs_a, sclk_a}, 4);
        while (busy_a) @(negedge clk);
        check(cfg_a == {1'b1, sel}, "R5 config bits", cfg_a, {1'b1, sel});
        check(rises_a == 16, "R4 mux frame edges", rises_a, 16);
        check(low_a == 2 * 16 * DIV_A, "R3 low time A", low_a, 2 * 16 * DIV_A);
        check(res_a == byte_v, "R7 result held A", res_a, byte_v);
    endtask

    task automatic xfer_b(input logic [7:0] byte_v);
        exp_b.push_back(byte_v);
        @(negedge clk);
        data_b  = byte_v;
        sel_b   = 2'b11;
        start_b = 1'b1;
        @(negedge clk);
        start_b = 1'b0;
        check(busy_b && !cs_b, "R2 start B", {busy_b, cs_b}, 2);
        while (busy_b) @(negedge clk);
        check(rises_b == 12, "R4 plain frame edges", rises_b, 12);
        check(!mhi_b, "R5 plain mosi idle", mhi_b, 0);
        check(low_b == 2 * 12 * DIV_B, "R3 low time B", low_b, 2 * 12 * DIV_B);
    endtask

    initial begin
        int wd = 0;
        while (wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        check(1'b0, "R4 watchdog", wd, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(cs_a && !sclk_a && !busy_a && !valid_a, "R1 reset A", {cs_a, sclk_a, busy_a, valid_a}, 8);
        check(cs_b && !sclk_b && !busy_b && !valid_b, "R1 reset B", {cs_b, sclk_b, busy_b, valid_b}, 8);
        rst = 1'b0;
        @(negedge clk);
        check(cs_a && !sclk_a && !busy_a && !valid_a, "R1 after reset A", {cs_a, sclk_a, busy_a, valid_a}, 8);

        // R5 R6: all select codes, data patterns against ones on null bits
        xfer_a(2'b00, 8'h00);
        xfer_a(2'b01, 8'hA5);
        xfer_a(2'b10, 8'h81);
        xfer_a(2'b11, 8'hFF);

        xfer_b(8'h00);
        xfer_b(8'h3C);
        xfer_b(8'hFE);

        // R8: start during a frame is ignored
        exp_a.push_back(8'h5A);
        @(negedge clk);
        data_a  = 8'h5A;
        sel_a   = 2'b10;
        start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        repeat (20) @(negedge clk);
        sel_a   = 2'b01;
        start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        while (busy_a) @(negedge clk);
        check(cfg_a == 3'b110, "R8 select unchanged", cfg_a, 3'b110);
        begin
            bit stayed = 1'b1;
            for (int i = 0; i < 10; i++) begin
                if (!cs_a || busy_a) stayed = 1'b0;
                @(negedge clk);
            end
            check(stayed, "R8 no second frame", stayed, 1);
        end

        // R9: back-to-back frames with start held high
        begin
            int base;
            base = valid_cnt_a;
            exp_a.push_back(8'h96);
            exp_a.push_back(8'h96);
            data_a  = 8'h96;
            sel_a   = 2'b00;
            start_a = 1'b1;
            while (valid_cnt_a < base + 2) @(negedge clk);
            start_a = 1'b0;
            while (busy_a) @(negedge clk);
            check(gap_a >= 2 * DIV_A, "R9 cs high gap", gap_a, 2 * DIV_A);
        end

        repeat (10) @(negedge clk);
        check(exp_a.size() == 0, "R7 all results A", exp_a.size(), 0);
        check(exp_b.size() == 0, "R7 all results B", exp_b.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule